// File: doc/BRIEF.md
# Interval Timer with Tick Catch-Up

This block is a per-core interval timer. A 64-bit cycle counter starts at zero on reset and rises by one on every clock. A 32-bit compare register is checked against the low half of that counter. When the two are equal, a level interrupt is raised. Software can mask that interrupt and clears it by writing an acknowledge bit.

On every match, a small hardware scheduler takes care of re-arming. It keeps an internal 64-bit expected-deadline value. It advances that value by one period per clock and counts the steps until the deadline is no longer behind the live counter. It then checks the deadline against a fixed guard window. Finally it loads the compare register and reports the number of elapsed periods with a one-cycle valid pulse. All "is it later" tests use unsigned differences, so a deadline that has already passed shows up as a huge value and is handled correctly.

Software sets the period before it turns the timer on. The period is the counter cycles per 10 ms, times 100, divided by the tick rate in Hz. A read/write register bus with a single address port gives access to the counter, the compare value, the period and the control bits.

Top module: `interval_tick_timer`

## Requirements
- R1: The counter is 64 bits wide, is 0 after reset and rises by exactly one per clock. A read at address 0 returns its low 32 bits and a read at address 1 returns its high 32 bits.
- R2: The compare register is written at address 2 and reads back as zero. A match occurs only while the timer is enabled, when the low 32 bits of the counter equal the compare value. While the timer is disabled, a match is ignored.
- R3: Writing control (address 4) with bit 0 set while the timer is disabled enables it. The expected deadline becomes the counter value in the write cycle plus the period, and the compare register is loaded with the low 32 bits of that deadline.
- R4: A match sets a pending flag. The output irq equals pending AND NOT mask, where mask is control bit 1. A match taken while masked stays pending, and irq rises in the cycle after the mask is cleared.
- R5: A control write with bit 2 set clears pending, and irq is low in the next cycle. A control write with bit 2 clear leaves pending unchanged.
- R6: After a match, the deadline is advanced by one period per step and each step is counted. Stepping continues while the unsigned 64-bit difference (deadline minus counter) exceeds the period. The step count is given on tick_count.
- R7: After stepping, one more period is added if the unsigned difference (deadline minus counter) is at most GUARD (default 500) or the deadline has already passed. The compare register is then loaded with the low 32 bits of the deadline.
- R8: If a match happens in cycle T and n periods are counted, tick_valid is high for exactly cycle T+n+2, and tick_count holds n during that cycle.
- R9: The period register is written and read at address 3. A re-arm uses the period value held at the match cycle, so a write before the match takes effect at that re-arm.
- R10: A read at address 4 returns enable in bit 0, mask in bit 1 and pending in bit 2. Reset clears all three, and also clears irq, tick_valid and tick_count.
- R11: When tick_valid is high, the compare value lies ahead of the low counter bits by a non-zero amount smaller than 2^31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Level interrupt, pending and not masked |
| tick_valid | output | 1 | One-cycle pulse after each re-arm |
| tick_count | output | 32 | Periods counted by the last re-arm |

## Verification
The bench drives matches that are late by different amounts against several periods. It checks the counted periods, the cycle of the valid pulse and the cycle of the following match. A design that compared the counter and deadline as signed values, or did not wrap the difference, would lose track of deadlines that have passed and would miscount, or would skip the next match by a whole counter wrap. Some cases leave the deadline inside the guard window or exactly one cycle behind the counter. A missing guard step makes the following match arrive one period early, or never. The remaining cases cover a masked match that must stay pending until unmasked, an acknowledge that must clear only when its bit is set, a match while disabled that must do nothing, and a period write just before a match that must be used by that re-arm.

// File: rtl/interval_tick_timer.sv
module interval_tick_timer #(
  parameter int CNT_W = 64,
  parameter int CMP_W = 32,
  parameter int GUARD = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        tick_valid,
  output logic [31:0] tick_count
);
  localparam logic [2:0] A_CLO = 3'd0, A_CHI = 3'd1, A_CMP = 3'd2, A_PER = 3'd3, A_CTL = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_CATCH, S_ARM} state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt, exp_t;
  logic [CMP_W-1:0]   cmp;
  logic [31:0]        period, per_q, n_q;
  logic               en, msk, pend;

  wire [CNT_W-1:0] per_x   = CNT_W'(per_q);
  wire [CNT_W-1:0] nxt     = exp_t + per_x;
  wire [CNT_W-1:0] gap_nxt = nxt - cnt;
  wire [CNT_W-1:0] gap_arm = exp_t - cnt;
  wire             late    = (gap_arm <= CNT_W'(GUARD)) || (gap_arm > per_x);
  wire [CNT_W-1:0] fin     = late ? nxt : exp_t;
  wire             ctl_wr  = wr_en && addr == A_CTL;
  wire             match   = en && st == S_IDLE && cnt[CMP_W-1:0] == cmp;

  assign irq = pend && !msk;

  always_comb begin
    case (addr)
      A_CLO:   rdata = cnt[31:0];
      A_CHI:   rdata = cnt[63:32];
      A_PER:   rdata = period;
      A_CTL:   rdata = {29'd0, pend, msk, en};
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      exp_t      <= '0;
      cmp        <= '0;
      period     <= '0;
      per_q      <= '0;
      n_q        <= '0;
      en         <= 1'b0;
      msk        <= 1'b0;
      pend       <= 1'b0;
      st         <= S_IDLE;
      tick_valid <= 1'b0;
      tick_count <= '0;
    end else begin
      cnt        <= cnt + 1'b1;
      tick_valid <= 1'b0;

      if (wr_en && addr == A_PER) period <= wdata;
      if (wr_en && addr == A_CMP) cmp <= wdata[CMP_W-1:0];
      if (ctl_wr) begin
        en  <= wdata[0];
        msk <= wdata[1];
        if (wdata[2]) pend <= 1'b0;
        if (wdata[0] && !en) begin
          exp_t <= cnt + CNT_W'(period);
          cmp   <= cnt[CMP_W-1:0] + period[CMP_W-1:0];
        end
      end

      case (st)
        S_IDLE: if (match) begin
          pend  <= 1'b1;
          per_q <= period;
          n_q   <= '0;
          st    <= S_CATCH;
        end
        S_CATCH: begin
          exp_t <= nxt;
          n_q   <= n_q + 1'b1;
          if (gap_nxt <= per_x) st <= S_ARM;
        end
        S_ARM: begin
          exp_t      <= fin;
          cmp        <= fin[CMP_W-1:0];
          tick_valid <= 1'b1;
          tick_count <= n_q;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module interval_tick_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [31:0] wdata,
  input logic [63:0] cnt,
  input logic [31:0] cmp,
  input logic [63:0] exp_t,
  input logic        pend,
  input logic        msk,
  input logic        irq,
  input logic        tick_valid,
  input logic [31:0] tick_count
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt == $past(cnt) + 64'd1); // R1
  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    msk |-> !irq); // R4
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(wr_en && addr == 3'd4 && wdata[2])) |=> pend); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4 && wdata[2] && cnt[31:0] != cmp) |=> !irq); // R5
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_valid |=> !tick_valid); // R8
  AST_COUNT_POS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_valid |-> tick_count != 32'd0); // R6
  AST_CMP_FROM_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_valid && !$past(wr_en && addr == 3'd2)) |-> cmp == exp_t[31:0]); // R7
  AST_DEADLINE_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    tick_valid |-> ((cmp - cnt[31:0]) != 32'd0 && (cmp - cnt[31:0]) < 32'h8000_0000)); // R11
endmodule

bind interval_tick_timer interval_tick_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt(cnt), .cmp(cmp), .exp_t(exp_t), .pend(pend), .msk(msk),
  .irq(irq), .tick_valid(tick_valid), .tick_count(tick_count));

// File: tb/interval_tick_timer_bench.sv
module interval_tick_timer_bench;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0, rdata, tick_count;
  logic        irq, tick_valid;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  interval_tick_timer u_interval_tick_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .tick_valid(tick_valid), .tick_count(tick_count));

  // period, lateness of forced compare, expected count, deadline multiple after re-arm
  localparam int VEC [8][4] = '{
    '{1000,    0, 1, 1},
    '{1000, 2500, 3, 4},
    '{1000, 1800, 2, 3},
    '{1000, 1200, 2, 2},
    '{ 800, 5000, 7, 7},
    '{2000, 1999, 1, 2},
    '{ 600,    0, 1, 1},
    '{ 600,  100, 1, 2}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = 3'd0; #0.1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #0.1; d = rdata; addr = 3'd0; #0.1;
  endtask

  task automatic enable_at(input logic [31:0] ctl, output logic [31:0] w);
    @(negedge clk); addr = 3'd0; #0.1; w = rdata;
    addr = 3'd4; wdata = ctl; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = 3'd0; #0.1;
  endtask

  task automatic wait_irq(output logic [31:0] c);
    while (!irq) @(negedge clk);
    #0.1; c = rdata;
  endtask

  task automatic wait_tv(output logic [31:0] n, output logic [31:0] c);
    while (!tick_valid) @(negedge clk);
    #0.1; n = tick_count; c = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v2, w, c, n, e0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 irq", {31'd0, irq}, 0);
    chk("R10 tick_valid", {31'd0, tick_valid}, 0);
    chk("R10 tick_count", tick_count, 0);
    chk("R1 counter held in reset", rdata, 0);
    rd(3'd4, v); chk("R10 ctrl", v, 0);
    rst_n = 1'b1;
    // R1 counter steps and high half
    rd(3'd0, v); rd(3'd0, v2); chk("R1 step", v2 - v, 1);
    rd(3'd1, v); chk("R1 high half", v, 0);
    // R9 / R2 register access
    wr(3'd3, 32'd1234); rd(3'd3, v); chk("R9 period readback", v, 1234);
    wr(3'd2, 32'h55); rd(3'd2, v); chk("R2 compare reads zero", v, 0);
    // R2 disabled timer ignores a match
    rd(3'd0, v); wr(3'd2, v + 20);
    repeat (40) @(negedge clk);
    chk("R2 no irq when disabled", {31'd0, irq}, 0);
    rd(3'd4, v); chk("R2 nothing pending", v, 0);

    // vector table: R3 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      wr(3'd4, 32'd4);
      wr(3'd3, VEC[i][0]);
      enable_at(32'd1, w);
      e0 = w + VEC[i][0];
      wr(3'd2, e0 + VEC[i][1]);
      wait_irq(c);
      chk($sformatf("R6 v%0d match cycle", i), c, e0 + VEC[i][1] + 1);
      wait_tv(n, c);
      chk($sformatf("R6 v%0d tick count", i), n, VEC[i][2]);
      chk($sformatf("R8 v%0d pulse cycle", i), c, e0 + VEC[i][1] + VEC[i][2] + 2);
      @(negedge clk);
      chk($sformatf("R8 v%0d pulse width", i), {31'd0, tick_valid}, 0);
      wr(3'd4, 32'd5);
      chk($sformatf("R5 v%0d ack", i), {31'd0, irq}, 0);
      wait_irq(c);
      chk($sformatf("R7 v%0d next deadline", i), c, e0 + VEC[i][3] * VEC[i][0] + 1);
      wait_tv(n, c);
      chk($sformatf("R6 v%0d steady count", i), n, 1);
    end

    // R3 enable arms one period out
    wr(3'd4, 32'd4);
    wr(3'd3, 32'd900);
    enable_at(32'd1, w);
    wait_irq(c);
    chk("R3 first match", c, w + 901);
    wait_tv(n, c);

    // R4 masked match stays pending; R5 write without ack bit keeps it
    wr(3'd4, 32'd4);
    wr(3'd3, 32'd1000);
    enable_at(32'd3, w);
    wait_tv(n, c);
    chk("R4 masked irq low", {31'd0, irq}, 0);
    rd(3'd4, v); chk("R4 pending while masked", v, 7);
    wr(3'd4, 32'd1);
    chk("R4 irq after unmask", {31'd0, irq}, 1);
    wr(3'd4, 32'd1);
    chk("R5 no ack keeps irq", {31'd0, irq}, 1);
    wr(3'd4, 32'd5);
    chk("R5 ack clears irq", {31'd0, irq}, 0);

    // R9 period written before a match is used by that re-arm
    wr(3'd4, 32'd4);
    wr(3'd3, 32'd1000);
    enable_at(32'd1, w);
    e0 = w + 1000;
    wr(3'd3, 32'd700);
    wait_irq(c);
    wait_tv(n, c);
    chk("R9 count with new period", n, 1);
    wr(3'd4, 32'd5);
    wait_irq(c);
    chk("R9 next deadline uses new period", c, e0 + 701);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule